// File: doc/BRIEF.md
# Payload XOR Stream Cipher Stage

This block sits in a switch data path as a single AXI4-Stream stage. It leaves the leading header beats of every packet untouched. Each later 32-bit word is combined by exclusive-OR with one 32-bit secret key, and every payload word uses that same key. Because XOR with the same key undoes itself, the one design serves both sides of a link. One instance scrambles traffic before transmission, and another, holding the same key, restores it after reception. Two stages in series with equal keys are therefore transparent.

The stage registers each beat once, so it adds exactly one cycle of latency. It accepts a new beat in every cycle in which the downstream side can take one. A key is loaded through a one-cycle write strobe. The new key is held pending and only becomes active between packets, so no packet is ever split across two keys. Header length is a parameter counted in beats from the start of each packet. Only bytes whose keep bit is set are altered.

Top module: `pxor_stage`

## Requirements
- R1: While and right after reset, `m_tvalid` is 0 and `s_tready` is 1, and the active key is all zeros.
- R2: A beat accepted on the input (`s_tvalid` and `s_tready` high at a rising edge) is presented on the output from the next edge on, with `m_tlast`, `m_tuser` and `m_tkeep` equal to the input values.
- R3: Beats 0 to HDR_WORDS-1 of each packet are forwarded unchanged. Beat numbering restarts at 0 after reset and after each beat with `tlast` set.
- R4: In every beat from index HDR_WORDS onward, byte lane b (bits 8b+7:8b) is XORed with key bits 8(b mod 4)+7:8(b mod 4).
- R5: A byte whose `s_tkeep` bit is 0 leaves the stage unchanged, whether it is header or payload.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, all output fields stay stable and no beat is lost or repeated.
- R7: While `m_tready` is 1, `s_tready` is 1, so back-to-back beats flow at one per cycle with no bubbles.
- R8: A key write (`key_wr_en` high for one edge, value on `key_wr_data`) is held pending. It becomes active only after a beat with `tlast` is accepted, or in an idle cycle between packets. A packet in flight keeps its old key to the end, and the next packet uses the new one.
- R9: Two stages in series that hold the same key deliver every packet bit-identical to the original.
- R10: Until the first key write, the key is zero, so payload is forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| key_wr_en | input | 1 | Key write strobe |
| key_wr_data | input | 32 | Key value to load |
| s_tdata | input | DATA_W | Input stream data |
| s_tkeep | input | DATA_W/8 | Input byte qualifiers |
| s_tuser | input | USER_W | Input sideband, passed through |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Stage can take a beat |
| m_tdata | output | DATA_W | Output stream data |
| m_tkeep | output | DATA_W/8 | Output byte qualifiers |
| m_tuser | output | USER_W | Output sideband |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream can take a beat |

## Verification
An accepted beat shows up on the output one edge later. The bench drives inputs just after a rising edge and reads the outputs at the following falling edge, so the single-beat latency check sees nothing before that edge and the beat right after it. Key writes reach the pending slot one edge after the strobe and swap in at the edge that accepts a `tlast` beat. Expected payload is therefore computed per packet from the key that was active when its first beat entered. Ready follows the downstream ready within the same cycle, so the no-bubble check samples it at every falling edge of a burst, and the beats captured from both stages are compared against the bench's own model once the pipeline has drained.

// File: rtl/pxor_pkg.sv
package pxor_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  typedef logic [WORD_W-1:0] key_word_t;
endpackage

// File: rtl/pxor_key_ctrl.sv
module pxor_key_ctrl
  import pxor_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  key_word_t wr_key,
  input  logic      beat_acc,
  input  logic      beat_last,
  output key_word_t key_active
);
  key_word_t pend_key_q, pend_key_d;
  key_word_t act_key_q, act_key_d;
  logic      pend_q, pend_d;
  logic      in_pkt_q, in_pkt_d;
  logic      swap;

  // swap only between packets: on the closing beat or in an idle gap
  always_comb begin
    swap       = pend_q & ((beat_acc & beat_last) | (~in_pkt_q & ~beat_acc));
    pend_key_d = wr_en ? wr_key : pend_key_q;
    pend_d     = wr_en | (pend_q & ~swap);
    act_key_d  = swap ? pend_key_q : act_key_q;
    in_pkt_d   = beat_acc ? ~beat_last : in_pkt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_key_q <= '0;
      act_key_q  <= '0;
      pend_q     <= 1'b0;
      in_pkt_q   <= 1'b0;
    end else begin
      pend_key_q <= pend_key_d;
      act_key_q  <= act_key_d;
      pend_q     <= pend_d;
      in_pkt_q   <= in_pkt_d;
    end
  end

  assign key_active = act_key_q;
endmodule

// File: rtl/pxor_hdr_track.sv
module pxor_hdr_track #(
  parameter int HDR_WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_acc,
  input  logic beat_last,
  output logic in_payload
);
  localparam int CW = $clog2(HDR_WORDS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HDR_WORDS);

  logic [CW-1:0] idx_q, idx_d;

  // beat index saturates once the header has been passed
  always_comb begin
    idx_d = idx_q;
    if (beat_acc) begin
      if (beat_last)           idx_d = '0;
      else if (idx_q != LIMIT) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign in_payload = (idx_q == LIMIT);
endmodule

// File: rtl/pxor_lanes.sv
module pxor_lanes
  import pxor_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   din,
  input  logic [DATA_W/8-1:0] keep,
  input  key_word_t           key,
  input  logic                enable,
  output logic [DATA_W-1:0]   dout
);
  localparam int NBYTES = DATA_W / BYTE_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int KOFF = (b % WORD_BYTES) * BYTE_W;
    assign dout[b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W] ^
      ((enable & keep[b]) ? key[KOFF +: BYTE_W] : {BYTE_W{1'b0}});
  end
endmodule

// File: rtl/pxor_stage.sv
module pxor_stage
  import pxor_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int USER_W    = 8,
  parameter int HDR_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_wr_en,
  input  logic [WORD_W-1:0]   key_wr_data,
  input  logic [DATA_W-1:0]   s_tdata,
  input  logic [DATA_W/8-1:0] s_tkeep,
  input  logic [USER_W-1:0]   s_tuser,
  input  logic                s_tlast,
  input  logic                s_tvalid,
  output logic                s_tready,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic [USER_W-1:0]   m_tuser,
  output logic                m_tlast,
  output logic                m_tvalid,
  input  logic                m_tready
);
  localparam int KEEP_W = DATA_W / BYTE_W;

  logic              acc;
  logic              in_payload;
  key_word_t         key_now;
  logic [DATA_W-1:0] xdata;

  logic              vld_q, vld_d;
  logic              last_q, last_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [KEEP_W-1:0] keep_q, keep_d;
  logic [USER_W-1:0] user_q, user_d;

  assign s_tready = ~vld_q | m_tready;
  assign acc      = s_tvalid & s_tready;

  pxor_key_ctrl u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (key_wr_en),
    .wr_key     (key_wr_data),
    .beat_acc   (acc),
    .beat_last  (s_tlast),
    .key_active (key_now)
  );

  pxor_hdr_track #(.HDR_WORDS(HDR_WORDS)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_acc   (acc),
    .beat_last  (s_tlast),
    .in_payload (in_payload)
  );

  pxor_lanes #(.DATA_W(DATA_W)) u_lanes (
    .din    (s_tdata),
    .keep   (s_tkeep),
    .key    (key_now),
    .enable (in_payload),
    .dout   (xdata)
  );

  // output register: load enable is the input handshake
  always_comb begin
    vld_d  = s_tready ? s_tvalid : vld_q;
    dat_d  = acc ? xdata   : dat_q;
    keep_d = acc ? s_tkeep : keep_q;
    user_d = acc ? s_tuser : user_q;
    last_d = acc ? s_tlast : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dat_q  <= '0;
      keep_q <= '0;
      user_q <= '0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      keep_q <= keep_d;
      user_q <= user_d;
      last_q <= last_d;
    end
  end

  assign m_tvalid = vld_q;
  assign m_tdata  = dat_q;
  assign m_tkeep  = keep_q;
  assign m_tuser  = user_q;
  assign m_tlast  = last_q;
endmodule

// File: rtl/pxor_stage_chk.sv
module pxor_stage_chk #(
  parameter int DATA_W = 32,
  parameter int USER_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DATA_W-1:0]   s_tdata,
  input logic [DATA_W/8-1:0] s_tkeep,
  input logic [USER_W-1:0]   s_tuser,
  input logic                s_tlast,
  input logic                s_tvalid,
  input logic                s_tready,
  input logic [DATA_W-1:0]   m_tdata,
  input logic [DATA_W/8-1:0] m_tkeep,
  input logic [USER_W-1:0]   m_tuser,
  input logic                m_tlast,
  input logic                m_tvalid,
  input logic                m_tready
);
  logic [DATA_W-1:0] clr_mask;
  for (genvar b = 0; b < DATA_W/8; b++) begin : g_m
    assign clr_mask[b*8 +: 8] = {8{~s_tkeep[b]}};
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!m_tvalid && s_tready));

  // R2
  fwd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |=> (m_tvalid && m_tlast == $past(s_tlast) &&
      m_tuser == $past(s_tuser) && m_tkeep == $past(s_tkeep)));

  // R5
  keep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |=>
      (((m_tdata ^ $past(s_tdata)) & $past(clr_mask)) == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
      $stable(m_tkeep) && $stable(m_tuser) && $stable(m_tlast)));

  // R7
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tready |-> s_tready);
endmodule

bind pxor_stage pxor_stage_chk #(.DATA_W(DATA_W), .USER_W(USER_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser),
  .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
  .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready)
);

// File: tb/pxor_stage_test.sv
`timescale 1ns/1ps
module pxor_stage_test;
  localparam int HDR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        k1_wr = 0, k2_wr = 0;
  logic [31:0] k1_val = 0, k2_val = 0;
  logic [31:0] s_data = 0;
  logic [3:0]  s_keep = 0;
  logic [7:0]  s_user = 0;
  logic        s_last = 0, s_valid = 0;
  logic        s_ready;
  logic [31:0] a_data; logic [3:0] a_keep; logic [7:0] a_user;
  logic        a_last, a_valid, a_ready;
  logic [31:0] b_data; logic [3:0] b_keep; logic [7:0] b_user;
  logic        b_last, b_valid;
  logic        tb_rdy = 1'b1;
  logic        bp_on = 1'b0;

  pxor_stage #(.HDR_WORDS(HDR)) uut (
    .clk(clk), .rst_n(rst_n), .key_wr_en(k1_wr), .key_wr_data(k1_val),
    .s_tdata(s_data), .s_tkeep(s_keep), .s_tuser(s_user), .s_tlast(s_last),
    .s_tvalid(s_valid), .s_tready(s_ready),
    .m_tdata(a_data), .m_tkeep(a_keep), .m_tuser(a_user), .m_tlast(a_last),
    .m_tvalid(a_valid), .m_tready(a_ready));

  pxor_stage #(.HDR_WORDS(HDR)) dec (
    .clk(clk), .rst_n(rst_n), .key_wr_en(k2_wr), .key_wr_data(k2_val),
    .s_tdata(a_data), .s_tkeep(a_keep), .s_tuser(a_user), .s_tlast(a_last),
    .s_tvalid(a_valid), .s_tready(a_ready),
    .m_tdata(b_data), .m_tkeep(b_keep), .m_tuser(b_user), .m_tlast(b_last),
    .m_tvalid(b_valid), .m_tready(tb_rdy));

  int checks = 0, fails = 0;

  // stimulus record and expected first-stage output
  logic [31:0] in_data [0:511];
  logic [3:0]  in_keep [0:511];
  logic [7:0]  in_user [0:511];
  logic        in_last [0:511];
  logic [31:0] ex1_data[0:511];
  int in_cnt = 0;

  // captured beats
  logic [31:0] c1_data [0:511]; logic [3:0] c1_keep [0:511];
  logic [7:0]  c1_user [0:511]; logic c1_last [0:511];
  logic [31:0] c2_data [0:511]; logic [3:0] c2_keep [0:511];
  logic [7:0]  c2_user [0:511]; logic c2_last [0:511];
  int c1_cnt = 0, c2_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && a_valid && a_ready && c1_cnt < 512) begin
      c1_data[c1_cnt] = a_data; c1_keep[c1_cnt] = a_keep;
      c1_user[c1_cnt] = a_user; c1_last[c1_cnt] = a_last;
      c1_cnt = c1_cnt + 1;
    end
    if (rst_n && b_valid && tb_rdy && c2_cnt < 512) begin
      c2_data[c2_cnt] = b_data; c2_keep[c2_cnt] = b_keep;
      c2_user[c2_cnt] = b_user; c2_last[c2_cnt] = b_last;
      c2_cnt = c2_cnt + 1;
    end
  end

  // downstream ready pattern, changed just after each rising edge
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5A;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tb_rdy = bp_on ? lfsr[0] : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] d, input logic [3:0] k,
                                        input int idx, input logic [31:0] key);
    logic [31:0] r;
    r = d;
    if (idx >= HDR)
      for (int b = 0; b < 4; b++)
        if (k[b]) r[b*8 +: 8] = d[b*8 +: 8] ^ key[b*8 +: 8];
    return r;
  endfunction

  task automatic write_keys(input logic [31:0] v);
    @(posedge clk); #1;
    k1_wr = 1; k1_val = v; k2_wr = 1; k2_val = v;
    @(posedge clk); #1;
    k1_wr = 0; k2_wr = 0;
    repeat (3) @(posedge clk);
  endtask

  // sends one packet; optionally strobes a key write to both stages with beat wr_at
  task automatic send_pkt(input int n, input logic [31:0] seed, input logic [3:0] lkeep,
                          input logic [7:0] usr, input logic [31:0] key,
                          input int wr_at, input logic [31:0] wr_val);
    for (int j = 0; j < n; j++) begin
      logic [31:0] d;
      logic [3:0]  k;
      d = seed + j * 32'h1F3D_5B79;
      k = (j == n - 1) ? lkeep : 4'hF;
      in_data[in_cnt] = d; in_keep[in_cnt] = k; in_user[in_cnt] = usr + 8'(j);
      in_last[in_cnt] = (j == n - 1); ex1_data[in_cnt] = model(d, k, j, key);
      in_cnt++;
      @(posedge clk); #1;
      s_valid = 1; s_data = d; s_keep = k; s_user = usr + 8'(j); s_last = (j == n - 1);
      if (j == wr_at) begin k1_wr = 1; k1_val = wr_val; k2_wr = 1; k2_val = wr_val; end
      else begin k1_wr = 0; k2_wr = 0; end
      @(negedge clk);
      while (!s_ready) @(negedge clk);
    end
    @(posedge clk); #1;
    s_valid = 0; s_last = 0; k1_wr = 0; k2_wr = 0;
  endtask

  task automatic drain_and_compare(input int base, input int n, input string req);
    int t;
    t = 0;
    while ((c1_cnt < base + n || c2_cnt < base + n) && t < 2000) begin
      @(negedge clk); t++;
    end
    check(c1_cnt == base + n, req, "stage1 beat count", c1_cnt, base + n);
    check(c2_cnt == base + n, "R9", "stage2 beat count", c2_cnt, base + n);
    for (int i = base; i < base + n && i < c1_cnt && i < c2_cnt; i++) begin
      check(c1_data[i] == ex1_data[i], req, "stage1 data", c1_data[i], ex1_data[i]);
      check(c1_keep[i] == in_keep[i] && c1_user[i] == in_user[i] && c1_last[i] == in_last[i],
            "R2", "sideband", {c1_keep[i], c1_user[i], 3'b0, c1_last[i]},
            {in_keep[i], in_user[i], 3'b0, in_last[i]});
      check(c2_data[i] == in_data[i] && c2_last[i] == in_last[i], "R9",
            "round trip data", c2_data[i], in_data[i]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(a_valid == 0, "R1", "m_tvalid in reset", a_valid, 0);
    check(s_ready == 1, "R1", "s_tready in reset", s_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(a_valid == 0 && s_ready == 1, "R1", "idle after reset", {a_valid, s_ready}, 2'b01);
  endtask

  task automatic t_zero_key();
    int base;
    base = in_cnt;
    // R10: no key written yet, payload must pass unchanged
    send_pkt(7, 32'hA5A5_0001, 4'hF, 8'h10, 32'h0, -1, 0);
    drain_and_compare(base, 7, "R10");
    for (int i = base; i < base + 7; i++)
      check(c1_data[i] == in_data[i], "R10", "zero key passthrough", c1_data[i], in_data[i]);
  endtask

  task automatic t_basic(input logic [31:0] key);
    int base;
    write_keys(key);
    base = in_cnt;
    // R3 R4 R5: 9 beats, last keeps bytes 0 and 1 only
    send_pkt(9, 32'h1234_5678, 4'b0011, 8'h20, key, -1, 0);
    send_pkt(2, 32'hCAFE_0000, 4'b0001, 8'h30, key, -1, 0);
    send_pkt(5, 32'h0BAD_F00D, 4'b1000, 8'h40, key, -1, 0);
    drain_and_compare(base, 16, "R4");
    check(c1_data[base + 10] == in_data[base + 10], "R3", "short packet header beat",
          c1_data[base + 10], in_data[base + 10]);
    check(c1_data[base + 15][23:0] == in_data[base + 15][23:0], "R5", "cleared keep bytes",
          c1_data[base + 15], in_data[base + 15]);
  endtask

  task automatic t_latency();
    int base1;
    base1 = c1_cnt;
    @(posedge clk); #1;
    s_valid = 1; s_data = 32'h7E57_0001; s_keep = 4'hF; s_user = 8'h55; s_last = 1;
    @(negedge clk);
    check(a_valid == 0, "R2", "no output before edge", a_valid, 0);
    @(posedge clk); #1;
    s_valid = 0; s_last = 0;
    @(negedge clk);
    check(a_valid == 1, "R2", "output one cycle later", a_valid, 1);
    check(a_data == 32'h7E57_0001 && a_user == 8'h55 && a_last == 1, "R2",
          "latency beat content", a_data, 32'h7E57_0001);
    repeat (4) @(negedge clk);
    check(c1_cnt == base1 + 1, "R6", "single beat not duplicated", c1_cnt, base1 + 1);
    // keep bookkeeping aligned: record the beat as stimulus
    in_data[in_cnt] = 32'h7E57_0001; in_keep[in_cnt] = 4'hF; in_user[in_cnt] = 8'h55;
    in_last[in_cnt] = 1; ex1_data[in_cnt] = 32'h7E57_0001; in_cnt++;
  endtask

  task automatic t_backpressure(input logic [31:0] key);
    int base;
    base = in_cnt;
    bp_on = 1;
    send_pkt(10, 32'h600D_0000, 4'hF, 8'h60, key, -1, 0);
    send_pkt(1, 32'h0000_1111, 4'h3, 8'h70, key, -1, 0);
    send_pkt(6, 32'hFEED_BEEF, 4'h7, 8'h80, key, -1, 0);
    drain_and_compare(base, 17, "R6");
    bp_on = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_throughput(input logic [31:0] key);
    int base, lows, cyc;
    base = in_cnt; lows = 0; cyc = 0;
    fork
      send_pkt(12, 32'h3333_0000, 4'hF, 8'h90, key, -1, 0);
      begin
        @(posedge clk); #1;
        while (s_valid) begin
          @(negedge clk);
          if (!s_ready) lows++;
          cyc++;
          @(posedge clk); #1;
        end
      end
    join
    check(lows == 0, "R7", "s_tready low during burst", lows, 0);
    check(cyc == 12, "R7", "cycles for 12 beats", cyc, 12);
    drain_and_compare(base, 12, "R7");
  endtask

  task automatic t_key_boundary(input logic [31:0] k_old, input logic [31:0] k_new);
    int base;
    base = in_cnt;
    // R8: new key written mid-packet applies from the next packet
    send_pkt(8, 32'h4444_0000, 4'hF, 8'hA0, k_old, 5, k_new);
    send_pkt(7, 32'h5555_0000, 4'hF, 8'hB0, k_new, -1, 0);
    drain_and_compare(base, 15, "R8");
    check(c1_data[base + 7] == (in_data[base + 7] ^ k_old), "R8", "old key to end of packet",
          c1_data[base + 7], in_data[base + 7] ^ k_old);
    check(c1_data[base + 12] == (in_data[base + 12] ^ k_new), "R8", "new key next packet",
          c1_data[base + 12], in_data[base + 12] ^ k_new);
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_zero_key();
    t_basic(32'hB1C2_D3E4);
    t_latency();
    t_backpressure(32'hB1C2_D3E4);
    t_throughput(32'hB1C2_D3E4);
    t_key_boundary(32'hB1C2_D3E4, 32'h0F1E_2D3C);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule